// File: doc/BRIEF.md
# Oversampling Serial Receiver with Per-Character Status

This block receives asynchronous serial characters from a single input line. A baud tick from outside sets the sampling rate. Each bit period lasts 16 ticks, or 8 ticks when double speed is selected. The block confirms the start bit by a majority vote and then assembles 5 to 9 data bits, least significant first. An optional parity bit follows the data, and one stop bit ends the frame.

Each finished character is stored together with its own frame-error and parity-error flags. Storage is a two-entry queue plus one holding register, which plays the part of the finished shift register. The read side always shows the oldest character and its flags. A pop strobe advances to the next one.

The block also reports overrun. It supports an addressed-network mode that discards frames not marked as addresses, and it raises an interrupt request while unread data exists.

Top module: `serial_rx_core`

## Requirements
- R1: A frame is one low start bit, N data bits sent least significant first, an optional parity bit and a high stop bit. N is set by `len_sel`: 0, 1, 2 and 3 select 5, 6, 7 and 8 bits, and 4 to 7 select 9 bits. `rd_data` carries the character right-aligned, with all unused upper bits at 0.
- R2: With `dbl_speed`=0 a bit lasts 16 baud ticks, and the bit value is the majority of the tick samples numbered 8, 9 and 10 in that bit. With `dbl_speed`=1 a bit lasts 8 ticks and samples 4, 5 and 6 vote. A low pulse that loses the start-bit vote returns the receiver to idle and stores nothing.
- R3: `rd_frame_err` is 1 for the head character exactly when its stop bit voted 0.
- R4: The parity bit follows the last data bit whenever `par_en`=1. With `par_odd`=0 the data bits and the parity bit must XOR to 0, and with `par_odd`=1 they must XOR to 1. `rd_parity_err` is 1 for a character only if `par_en` was 1 when that character finished and the check failed.
- R5: Up to two characters wait in the queue, and one more waits in the holding register. They are read oldest first. `rd_valid` is 1 while the queue is non-empty. A pop advances data and flags together, and it moves a held character into the queue.
- R6: `rd_overrun` becomes 1 when a start bit is confirmed while the queue is full and a character is held. The held character is then lost and the queued characters are kept. `rd_overrun` clears on the next pop.
- R7: With `mp_mode`=1, a frame whose last data bit is 0 is discarded and never stored. Frames whose last data bit is 1 are stored.
- R8: `irq` is 1 exactly when `rxc_ie`=1, `global_ie`=1 and `rd_valid`=1.
- R9: While `rx_enable`=0, the queue, the holding register and the overrun flag are cleared and the receiver stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enable; 0 flushes all stored state |
| baud_tick | input | 1 | One pulse per oversampling tick |
| rx_in | input | 1 | Serial data line, idle high |
| dbl_speed | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| len_sel | input | 3 | Data length select (see R1) |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| mp_mode | input | 1 | Discard frames whose last data bit is 0 |
| rxc_ie | input | 1 | Receive interrupt enable |
| global_ie | input | 1 | Global interrupt enable |
| rd_pop | input | 1 | Pops the head character |
| rd_data | output | 9 | Head character data |
| rd_valid | output | 1 | At least one unread character |
| rd_frame_err | output | 1 | Stop-bit error of the head character |
| rd_parity_err | output | 1 | Parity error of the head character |
| rd_overrun | output | 1 | Overrun occurred since the last pop |
| irq | output | 1 | Receive interrupt request |

## Verification
Two events can land in the same cycle. One is a pop that frees a queue slot. The other is the receiver finishing a character, or confirming a start bit, while a character is held. A pop frees the slot the held character moves into, and a confirmed start bit destroys that same held character, so the order of the two decides which characters survive. The bench fills the queue and the holding register, sends one more frame before any pop, and then reads back. It expects the first, second and fourth characters, with the overrun flag shown only alongside the first.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int MAX_BITS = 9;
  localparam int OVS_MAX  = 16;
  localparam int CNT_W    = $clog2(OVS_MAX + 1);

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                fe;
    logic                pe;
  } rx_char_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } rx_state_e;
endpackage

// File: rtl/rxs_sampler.sv
module rxs_sampler
  import rxs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       rx_in,
  input  logic       dbl,
  input  logic [2:0] len_sel,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       start_ok,
  output logic       done,
  output logic       addr_bit,
  output rx_char_t   ch
);
  logic                s1_q, s2_q;
  rx_state_e           st_q, st_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n, ovs, vpt;
  logic [1:0]          samp_q, samp_n;
  logic [3:0]          bit_q, bit_n, nbits;
  logic [MAX_BITS-1:0] sh_q, sh_n;
  logic                par_q, par_n;
  logic                maj, at_vote, at_end;

  assign ovs     = dbl ? CNT_W'(8) : CNT_W'(16);
  assign vpt     = dbl ? CNT_W'(6) : CNT_W'(10);
  assign nbits   = (len_sel > 3'd3) ? 4'd9 : ({1'b0, len_sel} + 4'd5);
  assign at_vote = tick && (cnt_q == vpt);
  assign at_end  = tick && (cnt_q == ovs);
  assign maj     = (samp_q[1] & samp_q[0]) | (samp_q[1] & s2_q) | (samp_q[0] & s2_q);

  // next state
  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    samp_n   = samp_q;
    bit_n    = bit_q;
    sh_n     = sh_q;
    par_n    = par_q;
    start_ok = 1'b0;
    done     = 1'b0;
    if (tick && st_q != S_IDLE) begin
      cnt_n = (cnt_q == ovs) ? CNT_W'(1) : cnt_q + CNT_W'(1);
      if (cnt_q >= vpt - CNT_W'(2) && cnt_q < vpt) samp_n = {samp_q[0], s2_q};
    end
    case (st_q)
      S_IDLE: if (tick && !s2_q) begin
        st_n  = S_START;
        cnt_n = CNT_W'(1);
        bit_n = '0;
        sh_n  = '0;
      end
      S_START: begin
        if (at_vote) begin
          if (maj) st_n = S_IDLE;
          else     start_ok = 1'b1;
        end else if (at_end) st_n = S_DATA;
      end
      S_DATA: begin
        if (at_vote) sh_n[bit_q] = maj;
        if (at_end) begin
          if (bit_q == nbits - 4'd1) st_n = par_en ? S_PAR : S_STOP;
          else                       bit_n = bit_q + 4'd1;
        end
      end
      S_PAR: begin
        if (at_vote)     par_n = maj;
        else if (at_end) st_n  = S_STOP;
      end
      S_STOP: if (at_vote) begin
        done = 1'b1;
        st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
    if (!en) begin
      st_n     = S_IDLE;
      start_ok = 1'b0;
      done     = 1'b0;
    end
  end

  assign ch.data  = sh_q;
  assign ch.fe    = ~maj;
  assign ch.pe    = par_en & (^sh_q ^ par_q ^ par_odd);
  assign addr_bit = sh_q[nbits - 4'd1];

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      samp_q <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
    end else begin
      s1_q   <= rx_in;
      s2_q   <= s1_q;
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      samp_q <= samp_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      par_q  <= par_n;
    end
  end

  // R2
  confirm_in_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (st_q == S_START || st_q == S_DATA));
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo
  import rxs_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush,
  input  logic     push,
  input  rx_char_t wdata,
  input  logic     pop,
  output rx_char_t head,
  output logic     nempty,
  output logic     full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rx_char_t        mem [DEPTH];
  logic [PW-1:0]   wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0]   cnt_q, cnt_n;

  assign nempty = (cnt_q != '0);
  assign full   = (cnt_q == CW'(DEPTH));
  assign head   = mem[rd_q];

  // next state
  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (push) wr_n = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
      if (pop)  rd_n = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
      if (push && !pop)      cnt_n = cnt_q + CW'(1);
      else if (pop && !push) cnt_n = cnt_q - CW'(1);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      for (int i = 0; i < DEPTH; i++)
        if (push && !flush && wr_q == PW'(i)) mem[i] <= wdata;
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nempty);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import rxs_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_enable,
  input  logic                baud_tick,
  input  logic                rx_in,
  input  logic                dbl_speed,
  input  logic [2:0]          len_sel,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                mp_mode,
  input  logic                rxc_ie,
  input  logic                global_ie,
  input  logic                rd_pop,
  output logic [MAX_BITS-1:0] rd_data,
  output logic                rd_valid,
  output logic                rd_frame_err,
  output logic                rd_parity_err,
  output logic                rd_overrun,
  output logic                irq
);
  rx_char_t ch, head, wdata, hold_q, hold_n;
  logic     start_ok, done, addr_bit;
  logic     nempty, full, push, pop_ok, space, accept, flush;
  logic     hold_v_q, hold_v_n, ovr_q, ovr_n, ovr_evt;

  rxs_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .en(rx_enable), .tick(baud_tick), .rx_in(rx_in),
    .dbl(dbl_speed), .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
    .start_ok(start_ok), .done(done), .addr_bit(addr_bit), .ch(ch)
  );

  rxs_fifo #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .wdata(wdata),
    .pop(pop_ok), .head(head), .nempty(nempty), .full(full)
  );

  assign flush   = ~rx_enable;
  assign pop_ok  = rd_pop & nempty;
  assign space   = ~full | pop_ok;
  assign accept  = done & (~mp_mode | addr_bit);
  assign push    = ~flush & (hold_v_q ? space : (accept & space));
  assign wdata   = hold_v_q ? hold_q : ch;
  assign ovr_evt = start_ok & full & hold_v_q & ~pop_ok;

  // next state
  always_comb begin
    hold_n   = hold_q;
    hold_v_n = hold_v_q;
    ovr_n    = ovr_q;
    if (flush) begin
      hold_v_n = 1'b0;
      ovr_n    = 1'b0;
    end else begin
      if (pop_ok) ovr_n = 1'b0;
      if (ovr_evt) begin
        ovr_n    = 1'b1;
        hold_v_n = 1'b0;
      end else if (hold_v_q && push) begin
        hold_v_n = accept;
        hold_n   = ch;
      end else if (!hold_v_q && accept && !space) begin
        hold_v_n = 1'b1;
        hold_n   = ch;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      hold_v_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      hold_q   <= hold_n;
      hold_v_q <= hold_v_n;
      ovr_q    <= ovr_n;
    end
  end

  assign rd_data       = head.data;
  assign rd_valid      = nempty;
  assign rd_frame_err  = nempty & head.fe;
  assign rd_parity_err = nempty & head.pe;
  assign rd_overrun    = ovr_q;
  assign irq           = rxc_ie & global_ie & nempty;

  // R5
  hold_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v_q |-> full);
  // R6
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(hold_v_q && full && start_ok));
  // R7
  mp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mp_mode && !addr_bit && !hold_v_q) |-> !push);
  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> (!rd_valid && !rd_overrun && !hold_v_q));
endmodule

// File: tb/sim_serial_rx_core.sv
module sim_serial_rx_core;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_enable = 1'b0, baud_tick = 1'b0, rx_in = 1'b1, dbl_speed = 1'b0;
  logic [2:0] len_sel = 3'd3;
  logic       par_en = 1'b0, par_odd = 1'b0, mp_mode = 1'b0;
  logic       rxc_ie = 1'b0, global_ie = 1'b0, rd_pop = 1'b0;
  logic [8:0] rd_data;
  logic       rd_valid, rd_frame_err, rd_parity_err, rd_overrun, irq;

  int checks = 0;
  int errors = 0;

  serial_rx_core u0 (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .baud_tick(baud_tick),
    .rx_in(rx_in), .dbl_speed(dbl_speed), .len_sel(len_sel), .par_en(par_en),
    .par_odd(par_odd), .mp_mode(mp_mode), .rxc_ie(rxc_ie), .global_ie(global_ie),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_frame_err(rd_frame_err), .rd_parity_err(rd_parity_err),
    .rd_overrun(rd_overrun), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) baud_tick <= ~baud_tick;

  function automatic logic [8:0] len_mask(input int nb);
    return 9'((10'h1 << nb) - 1);
  endfunction

  function automatic logic par_bit(input logic [8:0] d, input int nb, input logic odd);
    return (^(d & len_mask(nb))) ^ odd;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int bits);
    int bl;
    bl = (dbl_speed ? 8 : 16) * TICK_DIV;
    rx_in = v;
    repeat (bl * bits) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int nb, input logic bad_par, input logic stop_v);
    len_sel = 3'(nb - 5);
    hold_line(1'b0, 1);
    for (int i = 0; i < nb; i++) hold_line(d[i], 1);
    if (par_en) hold_line(par_bit(d, nb, par_odd) ^ bad_par, 1);
    hold_line(stop_v, 1);
    hold_line(1'b1, 2);
  endtask

  task automatic pop();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_head(input string req, input logic [8:0] d, input logic fe,
                           input logic pe, input logic ov);
    check({req, " valid"}, rd_valid, 1);
    check({req, " data"}, rd_data, d);
    check({req, " frame_err"}, rd_frame_err, fe);
    check({req, " parity_err"}, rd_parity_err, pe);
    check({req, " overrun"}, rd_overrun, ov);
    pop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rx_enable = 1'b1;
    repeat (4) @(negedge clk);
    // R5 R8 reset state
    check("R5 reset valid", rd_valid, 0);
    check("R6 reset overrun", rd_overrun, 0);
    check("R8 reset irq", irq, 0);

    // R2 false start: low for a quarter bit only
    rx_in = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk);
    hold_line(1'b1, 3);
    check("R2 false start stores nothing", rd_valid, 0);

    // R1 R2 R3 R4 random frames, read back one by one
    for (int k = 0; k < 24; k++) begin
      int nb;
      logic [8:0] d;
      logic bp, sv;
      nb        = 5 + int'($urandom % 5);
      d         = 9'($urandom) & len_mask(nb);
      dbl_speed = 1'($urandom);
      par_en    = 1'($urandom);
      par_odd   = 1'($urandom);
      bp        = par_en & 1'($urandom);
      sv        = ($urandom % 4) != 0;
      send(d | ~len_mask(nb) & 9'($urandom), nb, bp, sv);
      read_head("R1 R2 R3 R4 random", d, ~sv, bp, 1'b0);
    end
    par_en = 1'b0;
    dbl_speed = 1'b0;

    // R5 flags advance with the queue
    send(9'h0A5, 8, 1'b0, 1'b0);
    par_en = 1'b1;
    send(9'h03C, 8, 1'b1, 1'b1);
    par_en = 1'b0;
    read_head("R5 first head", 9'h0A5, 1'b1, 1'b0, 1'b0);
    read_head("R5 second head", 9'h03C, 1'b0, 1'b1, 1'b0);
    check("R5 empty after two pops", rd_valid, 0);

    // R6 overrun: 1,2 queued, 3 held, 4 destroys 3
    send(9'h011, 8, 1'b0, 1'b1);
    send(9'h022, 8, 1'b0, 1'b1);
    send(9'h033, 8, 1'b0, 1'b1);
    check("R6 no overrun yet", rd_overrun, 0);
    send(9'h044, 8, 1'b0, 1'b1);
    read_head("R6 head keeps 1 with overrun", 9'h011, 1'b0, 1'b0, 1'b1);
    read_head("R6 second is 2", 9'h022, 1'b0, 1'b0, 1'b0);
    read_head("R6 third is 4", 9'h044, 1'b0, 1'b0, 1'b0);
    check("R6 held 3 lost", rd_valid, 0);

    // R7 addressed mode
    mp_mode = 1'b1;
    send(9'h0A5, 9, 1'b0, 1'b1);
    check("R7 9-bit data frame dropped", rd_valid, 0);
    send(9'h1C3, 9, 1'b0, 1'b1);
    read_head("R7 9-bit address kept", 9'h1C3, 1'b0, 1'b0, 1'b0);
    send(9'h005, 8, 1'b0, 1'b1);
    check("R7 8-bit data frame dropped", rd_valid, 0);
    send(9'h085, 8, 1'b0, 1'b1);
    read_head("R7 8-bit address kept", 9'h085, 1'b0, 1'b0, 1'b0);
    mp_mode = 1'b0;

    // R8 interrupt gating
    rxc_ie = 1'b1;
    send(9'h05A, 8, 1'b0, 1'b1);
    check("R8 global off", irq, 0);
    global_ie = 1'b1;
    @(negedge clk);
    check("R8 all enabled", irq, 1);
    rxc_ie = 1'b0;
    @(negedge clk);
    check("R8 local off", irq, 0);
    rxc_ie = 1'b1;
    pop();
    check("R8 empty", irq, 0);

    // R9 disable flushes
    send(9'h071, 8, 1'b0, 1'b1);
    send(9'h072, 8, 1'b0, 1'b1);
    send(9'h073, 8, 1'b0, 1'b1);
    send(9'h074, 8, 1'b0, 1'b1);
    check("R9 setup overrun", rd_overrun, 1);
    rx_enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 flushed valid", rd_valid, 0);
    check("R9 flushed overrun", rd_overrun, 0);
    rx_enable = 1'b1;
    @(negedge clk);
    check("R9 held lost", rd_valid, 0);
    send(9'h0E7, 8, 1'b0, 1'b1);
    read_head("R9 after enable", 9'h0E7, 1'b0, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule